// File: doc/BRIEF.md
# Asymmetric-Frame SPI Controller

This block is a single-master SPI controller that runs one transaction per request. A transaction shifts a short command word out on COPI and then clocks a longer response word in from CIPO, both most significant bit first, in SPI mode 0. SCK idles low, COPI changes while SCK is low, and CIPO is captured while SCK is high. SCK toggles on every system clock while a frame is active, so one SCK period lasts two system clocks.

A 2-bit encoded peripheral code picks one of four devices on a shared bus. A frame-valid strobe marks the frame, so the devices decode the code only while it is high. A request is taken only on a rising edge of the start input. The code and the command word are captured on that edge. Start edges that arrive during a frame or during the following idle gap are dropped. The gap is a fixed number of system clocks during which SCK stays low and the block reports busy.

Command length, response length, gap length and peripheral count are parameters.

Top module: `spi_asym_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the outputs are as follows until a start edge arrives: `sck_o`, `copi_o`, `cs_valid_o`, `busy_o` and `done_o` are 0, and `rx_word_o` and `cs_code_o` are 0.
- R2: A frame begins only when `start_i` is 1 in a cycle after a cycle in which it was 0. Holding `start_i` at 1 after a frame has been accepted starts no further frame.
- R3: A rising edge of `start_i` while `busy_o` is 1 is ignored. This applies both during the frame and during the idle gap. No frame is queued for later.
- R4: The clock edge that accepts a start latches `sel_i` into `cs_code_o`. From the next cycle `cs_valid_o` is 1 for exactly 2*(TX_W+RX_W) cycles, and `cs_code_o` does not change during that time.
- R5: `sck_o` is 0 whenever `cs_valid_o` is 0. In frame cycle k (k=0 is the first cycle with `cs_valid_o`=1), `sck_o` equals k mod 2. Each frame therefore has exactly TX_W+RX_W rising SCK edges.
- R6: In frame cycles 2b and 2b+1, `copi_o` carries bit TX_W-1-b of the latched command word for b < TX_W, and 0 for b >= TX_W. `copi_o` never changes at a rising SCK edge.
- R7: The response is captured from `cipo_i` in frame cycles 2b+1, for b from TX_W to TX_W+RX_W-1. The first captured bit becomes bit RX_W-1 of the received word.
- R8: `done_o` is 1 for exactly one cycle, the cycle after the last frame cycle. In that cycle `rx_word_o` holds the whole new response. `rx_word_o` changes at no other time.
- R9: After the last frame cycle, `busy_o` stays 1 with `sck_o` 0 for GAP cycles (counting the `done_o` cycle). A start edge in the first cycle with `busy_o`=0 is accepted.
- R10: `busy_o` rises in the cycle after an accepted start edge and stays 1 until the gap ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request; acted on at its rising edge only |
| sel_i | input | SEL_W (2) | Encoded peripheral code, sampled at the accepted start edge |
| tx_word_i | input | TX_W (8) | Command word, sampled at the accepted start edge |
| cipo_i | input | 1 | Serial data from the addressed peripheral |
| sck_o | output | 1 | Serial clock, mode 0 |
| copi_o | output | 1 | Serial data to the peripheral |
| cs_code_o | output | SEL_W (2) | Latched peripheral code |
| cs_valid_o | output | 1 | High while a frame is on the bus |
| rx_word_o | output | RX_W (16) | Last received response word |
| busy_o | output | 1 | Frame or idle gap in progress |
| done_o | output | 1 | One-cycle pulse when the response is complete |

## Verification
The hardest situations to reach from the ports are the boundaries of the busy window. These are a start edge in the very last gap cycle, which must be dropped, and a start edge in the first idle cycle, which must be taken. The stimulus gets there by watching `busy_o` at the falling clock edge and raising `start_i` at exactly that moment. Re-trigger pulses are also placed in the middle of a frame and inside the gap. A behavioural model in the bench follows the frame by cycle number and compares every output on every clock. This catches both a dropped boundary request and a spurious extra frame.

// File: rtl/spi_asym_pkg.sv
package spi_asym_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_XFER = 2'd1,
      ST_GAP  = 2'd2
   } seq_state_e;

endpackage

// File: rtl/spi_asym_edge.sv
// Rising-edge detector for the request input.
module spi_asym_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic rise_o
);

   logic lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= lvl_i;
   end

   assign rise_o = lvl_i & ~lvl_q;

endmodule

// File: rtl/spi_asym_seq.sv
// Frame sequencer: SCK generation, bit counting, idle gap.
module spi_asym_seq
   import spi_asym_pkg::*;
#(
   parameter int TX_W = 8,
   parameter int RX_W = 16,
   parameter int GAP  = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rise_i,
   output logic load_o,
   output logic tx_adv_o,
   output logic rx_cap_o,
   output logic rx_last_o,
   output logic sck_o,
   output logic frame_o,
   output logic busy_o,
   output logic done_o
);

   localparam int NBITS = TX_W + RX_W;
   localparam int BCW   = (NBITS > 1) ? $clog2(NBITS) : 1;
   localparam int GCW   = (GAP > 1) ? $clog2(GAP) : 1;
   localparam logic [BCW-1:0] B_TXEND = BCW'(TX_W);
   localparam logic [BCW-1:0] B_LAST  = BCW'(NBITS - 1);
   localparam logic [GCW-1:0] G_LAST  = GCW'(GAP - 1);

   seq_state_e     state_q;
   logic [BCW-1:0] bcnt_q;
   logic [GCW-1:0] gcnt_q;
   logic           sck_q;
   logic           done_q;
   logic           fall;
   logic           last_bit;

   assign load_o    = (state_q == ST_IDLE) && rise_i;
   assign fall      = (state_q == ST_XFER) && sck_q;
   assign last_bit  = (bcnt_q == B_LAST);
   assign tx_adv_o  = fall && (bcnt_q < B_TXEND);
   assign rx_cap_o  = fall && (bcnt_q >= B_TXEND);
   assign rx_last_o = fall && last_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         bcnt_q  <= '0;
         gcnt_q  <= '0;
         sck_q   <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (rise_i) begin
                  state_q <= ST_XFER;
                  bcnt_q  <= '0;
                  sck_q   <= 1'b0;
               end
            end
            ST_XFER: begin
               sck_q <= ~sck_q;
               if (sck_q) begin
                  if (last_bit) begin
                     state_q <= ST_GAP;
                     gcnt_q  <= '0;
                     done_q  <= 1'b1;
                  end else begin
                     bcnt_q <= bcnt_q + 1'b1;
                  end
               end
            end
            ST_GAP: begin
               if (gcnt_q == G_LAST) state_q <= ST_IDLE;
               else                  gcnt_q  <= gcnt_q + 1'b1;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign sck_o   = sck_q;
   assign frame_o = (state_q == ST_XFER);
   assign busy_o  = (state_q != ST_IDLE);
   assign done_o  = done_q;

   // R9: SCK held low throughout the idle gap
   p_gap_sck_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_GAP) |-> !sck_q);

   // R8: completion pulse lasts one cycle
   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   // R9: the gap starts with the done pulse
   p_gap_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state_q == ST_GAP) |-> done_q);

   // R3: no new frame from inside the gap
   p_gap_no_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_GAP) |=> (state_q != ST_XFER));

endmodule

// File: rtl/spi_asym_shift.sv
// Command serializer and response deserializer.
module spi_asym_shift #(
   parameter int TX_W = 8,
   parameter int RX_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load_i,
   input  logic [TX_W-1:0] tx_word_i,
   input  logic            tx_adv_i,
   input  logic            rx_cap_i,
   input  logic            rx_last_i,
   input  logic            cipo_i,
   output logic            copi_o,
   output logic [RX_W-1:0] rx_word_o
);

   logic [TX_W-1:0] tx_sh_q;
   logic [TX_W-1:0] tx_next;
   logic [RX_W-1:0] rx_sh_q;
   logic [RX_W-1:0] rx_next;
   logic [RX_W-1:0] rx_word_q;

   generate
      if (TX_W > 1) begin : g_tx_wide
         assign tx_next = {tx_sh_q[TX_W-2:0], 1'b0};
      end else begin : g_tx_one
         assign tx_next = 1'b0;
      end
      if (RX_W > 1) begin : g_rx_wide
         assign rx_next = {rx_sh_q[RX_W-2:0], cipo_i};
      end else begin : g_rx_one
         assign rx_next = cipo_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh_q   <= '0;
         rx_sh_q   <= '0;
         rx_word_q <= '0;
      end else begin
         if (load_i)        tx_sh_q <= tx_word_i;
         else if (tx_adv_i) tx_sh_q <= tx_next;
         if (rx_cap_i)      rx_sh_q <= rx_next;
         if (rx_last_i)     rx_word_q <= rx_next;
      end
   end

   assign copi_o    = tx_sh_q[TX_W-1];
   assign rx_word_o = rx_word_q;

   // R7: the final capture is also a shift-register capture
   p_last_is_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_last_i |-> rx_cap_i);

   // R6: command bits never advance while a response bit is captured
   p_tx_rx_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_adv_i && rx_cap_i));

endmodule

// File: rtl/spi_asym_ctrl.sv
// SPI controller: short command out, longer response in, encoded select.
module spi_asym_ctrl #(
   parameter int TX_W     = 8,
   parameter int RX_W     = 16,
   parameter int GAP      = 5,
   parameter int N_PERIPH = 4,
   parameter int SEL_W    = $clog2(N_PERIPH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [SEL_W-1:0] sel_i,
   input  logic [TX_W-1:0]  tx_word_i,
   input  logic             cipo_i,
   output logic             sck_o,
   output logic             copi_o,
   output logic [SEL_W-1:0] cs_code_o,
   output logic             cs_valid_o,
   output logic [RX_W-1:0]  rx_word_o,
   output logic             busy_o,
   output logic             done_o
);

   generate
      if (TX_W < 1)  begin : g_bad_tx  $error("TX_W must be at least 1"); end
      if (RX_W < 1)  begin : g_bad_rx  $error("RX_W must be at least 1"); end
      if (GAP < 1)   begin : g_bad_gap $error("GAP must be at least 1"); end
      if (N_PERIPH < 2 || (1 << SEL_W) < N_PERIPH) begin : g_bad_sel
         $error("SEL_W too narrow for N_PERIPH");
      end
   endgenerate

   logic rise;
   logic load;
   logic tx_adv;
   logic rx_cap;
   logic rx_last;
   logic [SEL_W-1:0] cs_q;

   spi_asym_edge u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (start_i),
      .rise_o (rise)
   );

   spi_asym_seq #(.TX_W(TX_W), .RX_W(RX_W), .GAP(GAP)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .rise_i    (rise),
      .load_o    (load),
      .tx_adv_o  (tx_adv),
      .rx_cap_o  (rx_cap),
      .rx_last_o (rx_last),
      .sck_o     (sck_o),
      .frame_o   (cs_valid_o),
      .busy_o    (busy_o),
      .done_o    (done_o)
   );

   spi_asym_shift #(.TX_W(TX_W), .RX_W(RX_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (load),
      .tx_word_i (tx_word_i),
      .tx_adv_i  (tx_adv),
      .rx_cap_i  (rx_cap),
      .rx_last_i (rx_last),
      .cipo_i    (cipo_i),
      .copi_o    (copi_o),
      .rx_word_o (rx_word_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cs_q <= '0;
      else if (load) cs_q <= sel_i;
   end

   assign cs_code_o = cs_q;

   // R5: serial clock low outside a frame
   p_sck_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_valid_o |-> !sck_o);

   // R4: peripheral code steady across the frame
   p_cs_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_valid_o && $past(cs_valid_o)) |-> $stable(cs_code_o));

   // R6: data out never moves with a rising serial clock
   p_copi_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sck_o) |-> $stable(copi_o));

   // R8: received word changes only with the done pulse
   p_rx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(rx_word_o));

   // R10: a frame is always inside the busy window
   p_busy_cover_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cs_valid_o |-> busy_o);

endmodule

// File: tb/tb_spi_asym_ctrl.sv
`timescale 1ns/1ps
module tb_spi_asym_ctrl;

   localparam int TXW  = 8;
   localparam int RXW  = 16;
   localparam int GAPC = 5;
   localparam int NB   = TXW + RXW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic [1:0] sel_i = 2'd0;
   logic [TXW-1:0] tx_word_i = '0;
   logic cipo_i = 1'b0;
   logic sck_o, copi_o, cs_valid_o, busy_o, done_o;
   logic [1:0] cs_code_o;
   logic [RXW-1:0] rx_word_o;

   spi_asym_ctrl dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .sel_i(sel_i),
      .tx_word_i(tx_word_i), .cipo_i(cipo_i), .sck_o(sck_o), .copi_o(copi_o),
      .cs_code_o(cs_code_o), .cs_valid_o(cs_valid_o), .rx_word_o(rx_word_o),
      .busy_o(busy_o), .done_o(done_o)
   );

   always #2.5 clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;
   int n_done = 0;
   int n_rise = 0;
   logic sck_prev = 1'b0;

   // reference model state
   bit m_act = 0;
   int m_t = 0;
   bit m_prev = 0;
   logic [1:0] m_cs = '0;
   logic [TXW-1:0] m_tx = '0;
   logic [RXW-1:0] m_rxsh = '0;
   logic [RXW-1:0] m_rx = '0;
   logic [RXW-1:0] resp = '0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_act = 0; m_prev = 0; m_rx = '0; m_cs = '0;
      end else begin
         bit rise;
         rise = start_i && !m_prev;
         m_prev = start_i;
         if (m_act) begin
            if ((m_t % 2 == 1) && (m_t / 2 >= TXW) && (m_t < 2*NB))
               m_rxsh = {m_rxsh[RXW-2:0], cipo_i};
            m_t++;
            if (m_t == 2*NB) m_rx = m_rxsh;
            if (m_t >= 2*NB + GAPC) m_act = 0;
         end else if (rise) begin
            m_act = 1; m_t = 0; m_cs = sel_i; m_tx = tx_word_i;
         end
      end
   end

   always @(negedge clk) begin
      bit fr;
      int b;
      logic e_copi;
      fr = m_act && (m_t < 2*NB);
      b = m_t / 2;
      e_copi = (fr && b < TXW) ? m_tx[TXW-1-b] : 1'b0;
      if (rst_n) begin
         chk(sck_o == (fr ? m_t[0] : 1'b0), "R5 sck", sck_o, fr ? m_t[0] : 0);
         chk(cs_valid_o == fr, "R4 cs_valid", cs_valid_o, fr);
         chk(cs_code_o == m_cs, "R4 cs_code", cs_code_o, m_cs);
         chk(copi_o == e_copi, "R6 copi", copi_o, e_copi);
         chk(busy_o == m_act, "R10 busy", busy_o, m_act);
         chk(done_o == (m_act && m_t == 2*NB), "R8 done", done_o, m_act && m_t == 2*NB);
         chk(rx_word_o == m_rx, "R7 rx_word", rx_word_o, m_rx);
         if (sck_o && !sck_prev) n_rise++;
         if (done_o) begin
            n_done++;
            chk(n_rise == NB, "R5 sck rising count", n_rise, NB);
            n_rise = 0;
         end
      end
      sck_prev = sck_o;
      cipo_i = (fr && b >= TXW) ? resp[RXW-1-(b-TXW)] : 1'b0;
   end

   task automatic pulse_start();
      @(negedge clk) start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
   endtask

   task automatic wait_done();
      for (int i = 0; i < 200 && !done_o; i++) @(negedge clk);
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 200 && busy_o; i++) @(negedge clk);
   endtask

   task automatic frame(input logic [1:0] s, input logic [TXW-1:0] t, input logic [RXW-1:0] r);
      @(negedge clk);
      sel_i = s; tx_word_i = t; resp = r;
      pulse_start();
      wait_done();
      chk(rx_word_o == r, "R7 response", rx_word_o, r);
      wait_idle();
   endtask

   initial begin
      #500000;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      int d0;
      int gl;
      repeat (3) @(negedge clk);
      // R1 reset values while held in reset
      chk({sck_o, copi_o, cs_valid_o, busy_o, done_o} == 5'b0, "R1 reset outputs", {sck_o, copi_o, cs_valid_o, busy_o, done_o}, 0);
      chk(rx_word_o == 0 && cs_code_o == 0, "R1 reset words", rx_word_o, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(busy_o == 1'b0, "R1 idle after reset", busy_o, 0);

      // basic frames, every peripheral code and corner patterns (R4, R6, R7)
      frame(2'd0, 8'hA5, 16'hBEEF);
      frame(2'd1, 8'h00, 16'hFFFF);
      frame(2'd2, 8'hFF, 16'h0000);
      frame(2'd3, 8'h81, 16'h8001);
      frame(2'd1, 8'h3C, 16'h5A96);

      // R2: level held high starts only one frame
      d0 = n_done;
      @(negedge clk);
      sel_i = 2'd2; tx_word_i = 8'h69; resp = 16'h1234;
      start_i = 1'b1;
      repeat (2*NB + GAPC + 30) @(negedge clk);
      chk(n_done == d0 + 1, "R2 level start", n_done, d0 + 1);
      chk(busy_o == 1'b0, "R2 no restart", busy_o, 0);
      start_i = 1'b0;

      // R3: re-triggers mid-frame and in the gap, with a new code
      d0 = n_done;
      @(negedge clk);
      sel_i = 2'd3; tx_word_i = 8'hC3; resp = 16'hCAFE;
      pulse_start();
      repeat (10) @(negedge clk);
      sel_i = 2'd0; tx_word_i = 8'h11;
      pulse_start();
      chk(cs_code_o == 2'd3, "R3 code kept", cs_code_o, 3);
      wait_done();
      pulse_start();
      wait_idle();
      repeat (30) @(negedge clk);
      chk(n_done == d0 + 1, "R3 retrigger ignored", n_done, d0 + 1);

      // R3: edge in the last gap cycle is dropped
      d0 = n_done;
      @(negedge clk);
      sel_i = 2'd1; tx_word_i = 8'h5A; resp = 16'h0F0F;
      pulse_start();
      wait_done();
      repeat (GAPC - 1) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (20) @(negedge clk);
      chk(n_done == d0 + 1 && !busy_o, "R3 last gap cycle", n_done, d0 + 1);

      // R9: gap length, then start accepted in first idle cycle
      @(negedge clk);
      sel_i = 2'd2; tx_word_i = 8'hE7; resp = 16'hA55A;
      pulse_start();
      wait_done();
      gl = 0;
      while (busy_o && gl < 100) begin
         gl++;
         @(negedge clk);
      end
      chk(gl == GAPC, "R9 gap length", gl, GAPC);
      sel_i = 2'd3; tx_word_i = 8'h96; resp = 16'h7E81;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o == 1'b1, "R9 back-to-back accept", busy_o, 1);
      wait_done();
      chk(rx_word_o == 16'h7E81, "R7 back-to-back response", rx_word_o, 16'h7E81);
      wait_idle();
      repeat (5) @(negedge clk);

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule